// File: doc/BRIEF.md
# MATS+ Memory Self-Test Controller

This block runs the MATS+ march test on a one-bit-wide RAM with single-cycle synchronous read and write. It has three parts. A nine-state sequencer steps through the three march elements. A decoder turns the current state into RAM and address-generator controls. An address multiplexer hands the RAM address, write enable and write data either to the functional logic or to the test. During the test the RAM address comes from an external up/down address stepper. The controller drives that stepper's direction and enable, and the stepper returns a flag that is high when it sits on the last address for the current direction.

The sequence has three elements. First, a zero is written to every word in ascending order. Second, in ascending order, each word is read with a zero expected and then written with a one. Third, in descending order, each word is read with a one expected and then written with a zero. Read data arrives one cycle after the read state, so each compare takes place in the write state that follows. The state count is fixed at two per element plus an idle state, a fail state and a pass state. When the run ends, control goes back to the functional path and the result stays on the outputs until reset.

Top module: `mats_bist`

## Requirements
- R1: During and after reset the controller is idle: `amux_sel`, `ag_en`, `done`, `pass` and `fail` are all 0.
- R2: While `amux_sel` is 0, `ram_addr`, `ram_we` and `ram_wdata` equal `func_addr`, `func_we` and `func_wdata` in the same cycle. While `amux_sel` is 1, `ram_addr` equals `ag_addr`.
- R3: `start` is sampled only in the idle state. A high `start` in the idle state begins the test on the next clock edge, with `amux_sel` going to 1. A `start` asserted after a run has ended has no effect on any output.
- R4: The first element writes 0 (`ram_wdata`=0) once to every address, stepping with `ag_up`=1, for N cycles, where N is 2^ADDR_W.
- R5: The second element reads and then writes 1 at each address in ascending order. The third element reads and then writes 0 at each address in descending order (`ag_up`=0). Each of these elements takes 2N cycles, and the full test writes 3N times.
- R6: Between the first and second element, one cycle pulses `ag_en` with `ag_up`=1 so the stepper wraps back to the first address. No step is taken between the second and third element. `ag_en` is never high outside the test.
- R7: Read data is compared one cycle after the read state. In the second element 0 is expected, and in the third element 1 is expected. On a mismatch the controller enters the fail state on the next edge, drives `done`=1, `fail`=1 and `amux_sel`=0, and holds these until reset.
- R8: If no mismatch occurs, the controller enters the pass state exactly 5N+1 cycles after the start edge and holds `done`=1 and `pass`=1 until reset.
- R9: `pass` and `fail` are never 1 together, and `done` equals `pass` OR `fail` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the test (sampled in idle only) |
| func_addr | input | ADDR_W | Functional RAM address |
| func_we | input | 1 | Functional write enable |
| func_wdata | input | 1 | Functional write data |
| ag_addr | input | ADDR_W | Address from the up/down stepper |
| ag_last | input | 1 | Stepper is on the last address for its direction |
| ram_rdata | input | 1 | RAM read data, one cycle after the address |
| ram_addr | output | ADDR_W | Address to the RAM row decoder |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 1 | RAM write data |
| amux_sel | output | 1 | 1 while the test owns the RAM |
| ag_en | output | 1 | Stepper advance enable |
| ag_up | output | 1 | Stepper direction, 1 = ascending |
| done | output | 1 | Test finished |
| pass | output | 1 | Test finished with no mismatch |
| fail | output | 1 | Test found a mismatch |

## Verification
The assertions check the cycle-level invariants on every cycle. These cover the multiplexer following its select in both modes, the result flags being exclusive, stable and consistent with `done`, the stepper being enabled only inside the test, and the test starting only after a `start` request. Other behaviour can only be shown by the bench's scenarios with a RAM and a stepper model around the block. That covers the order and data of the writes in each element, the wrap step between elements, the exact cycle at which a pass or fail appears, and detection of stuck cells in both the ascending and the descending read elements, including the first and last addresses.

// File: rtl/mats_pkg.sv
package mats_pkg;

    localparam int NUM_ELEM   = 3;
    localparam int NUM_STATES = 2 * NUM_ELEM + 3;
    localparam int ST_W       = $clog2(NUM_STATES);

    typedef enum logic [ST_W-1:0] {
        ST_IDLE,
        ST_E1_WR0,
        ST_E1_WRAP,
        ST_E2_RD,
        ST_E2_WR1,
        ST_E3_RD,
        ST_E3_WR0,
        ST_FAIL,
        ST_PASS
    } mats_state_e;

    typedef struct packed {
        logic sel;
        logic we;
        logic wd;
        logic ag_en;
        logic ag_up;
        logic done;
        logic pass;
        logic fail;
    } mats_ctl_t;

    function automatic logic in_test(mats_state_e s);
        return (s != ST_IDLE) && (s != ST_FAIL) && (s != ST_PASS);
    endfunction

    function automatic logic is_compare(mats_state_e s);
        return (s == ST_E2_WR1) || (s == ST_E3_WR0);
    endfunction

    function automatic logic expected_bit(mats_state_e s);
        return (s == ST_E3_WR0);
    endfunction

    function automatic logic is_write(mats_state_e s);
        return (s == ST_E1_WR0) || (s == ST_E2_WR1) || (s == ST_E3_WR0);
    endfunction

endpackage

// File: rtl/mats_decode.sv
module mats_decode
    import mats_pkg::*;
(
    input  mats_state_e state,
    input  logic        rdata,
    input  logic        ag_last,
    output logic        mismatch,
    output mats_ctl_t   ctl
);

    always_comb begin
        mismatch  = is_compare(state) && (rdata != expected_bit(state));
        ctl       = '0;
        ctl.sel   = in_test(state);
        ctl.we    = is_write(state);
        ctl.wd    = (state == ST_E2_WR1);
        ctl.ag_up = !((state == ST_E3_RD) || (state == ST_E3_WR0));
        ctl.ag_en = (state == ST_E1_WRAP) ||
                    (is_write(state) && !ag_last && !mismatch);
        ctl.fail  = (state == ST_FAIL);
        ctl.pass  = (state == ST_PASS);
        ctl.done  = ctl.fail || ctl.pass;
    end

endmodule

// File: rtl/mats_fsm.sv
module mats_fsm
    import mats_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        ag_last,
    input  logic        mismatch,
    output mats_state_e state
);

    mats_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start) nxt = ST_E1_WR0;
            ST_E1_WR0:  if (ag_last) nxt = ST_E1_WRAP;
            ST_E1_WRAP: nxt = ST_E2_RD;
            ST_E2_RD:   nxt = ST_E2_WR1;
            ST_E2_WR1:  if (mismatch)     nxt = ST_FAIL;
                        else if (ag_last) nxt = ST_E3_RD;
                        else              nxt = ST_E2_RD;
            ST_E3_RD:   nxt = ST_E3_WR0;
            ST_E3_WR0:  if (mismatch)     nxt = ST_FAIL;
                        else if (ag_last) nxt = ST_PASS;
                        else              nxt = ST_E3_RD;
            ST_FAIL:    nxt = ST_FAIL;
            ST_PASS:    nxt = ST_PASS;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

endmodule

// File: rtl/mats_mux.sv
module mats_mux #(
    parameter int AW = 4
) (
    input  logic          sel,
    input  logic [AW-1:0] func_addr,
    input  logic          func_we,
    input  logic          func_wdata,
    input  logic [AW-1:0] test_addr,
    input  logic          test_we,
    input  logic          test_wdata,
    output logic [AW-1:0] ram_addr,
    output logic          ram_we,
    output logic          ram_wdata
);

    always_comb begin
        if (sel) begin
            ram_addr  = test_addr;
            ram_we    = test_we;
            ram_wdata = test_wdata;
        end else begin
            ram_addr  = func_addr;
            ram_we    = func_we;
            ram_wdata = func_wdata;
        end
    end

endmodule

// File: rtl/mats_bist.sv
module mats_bist
    import mats_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] func_addr,
    input  logic              func_we,
    input  logic              func_wdata,
    input  logic [ADDR_W-1:0] ag_addr,
    input  logic              ag_last,
    input  logic              ram_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_we,
    output logic              ram_wdata,
    output logic              amux_sel,
    output logic              ag_en,
    output logic              ag_up,
    output logic              done,
    output logic              pass,
    output logic              fail
);

    mats_state_e state;
    mats_ctl_t   ctl;
    logic        mismatch;

    mats_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .ag_last  (ag_last),
        .mismatch (mismatch),
        .state    (state)
    );

    mats_decode u_dec (
        .state    (state),
        .rdata    (ram_rdata),
        .ag_last  (ag_last),
        .mismatch (mismatch),
        .ctl      (ctl)
    );

    mats_mux #(.AW(ADDR_W)) u_mux (
        .sel        (ctl.sel),
        .func_addr  (func_addr),
        .func_we    (func_we),
        .func_wdata (func_wdata),
        .test_addr  (ag_addr),
        .test_we    (ctl.we),
        .test_wdata (ctl.wd),
        .ram_addr   (ram_addr),
        .ram_we     (ram_we),
        .ram_wdata  (ram_wdata)
    );

    assign amux_sel = ctl.sel;
    assign ag_en    = ctl.ag_en;
    assign ag_up    = ctl.ag_up;
    assign done     = ctl.done;
    assign pass     = ctl.pass;
    assign fail     = ctl.fail;

endmodule

// File: rtl/mats_bist_chk.sv
module mats_bist_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [ADDR_W-1:0] func_addr,
    input logic              func_we,
    input logic              func_wdata,
    input logic [ADDR_W-1:0] ag_addr,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              ram_we,
    input logic              ram_wdata,
    input logic              amux_sel,
    input logic              ag_en,
    input logic              done,
    input logic              pass,
    input logic              fail
);

    p_idle_in_reset_r1: assert property (@(posedge clk)
        rst |=> (!amux_sel && !ag_en && !done));

    p_func_path_r2: assert property (@(posedge clk) disable iff (rst)
        !amux_sel |-> (ram_addr == func_addr && ram_we == func_we && ram_wdata == func_wdata));

    p_test_addr_r2: assert property (@(posedge clk) disable iff (rst)
        amux_sel |-> (ram_addr == ag_addr));

    p_start_needed_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(amux_sel) |-> $past(start));

    p_step_in_test_r6: assert property (@(posedge clk) disable iff (rst)
        ag_en |-> amux_sel);

    p_fail_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        fail |=> (fail && !amux_sel));

    p_pass_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        pass |=> (pass && !amux_sel));

    p_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
        !(pass && fail) && (done == (pass || fail)));

    p_done_ends_test_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> !amux_sel);

endmodule

bind mats_bist mats_bist_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/mats_bist_tb.sv
module mats_bist_tb;

    localparam int AW = 4;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] func_addr = '0;
    logic          func_we = 1'b0;
    logic          func_wdata = 1'b0;
    logic [AW-1:0] ag_addr;
    logic          ag_last;
    logic          ram_rdata;
    logic [AW-1:0] ram_addr;
    logic          ram_we, ram_wdata, amux_sel, ag_en, ag_up, done, pass, fail;

    int checks = 0;
    int errors = 0;
    int wr_idx;
    int wr_bad;
    int cyc = 0;

    logic          flt_on = 1'b0;
    logic [AW-1:0] flt_addr = '0;
    logic          flt_val = 1'b0;
    logic [N-1:0]  mem;

    always #5 clk = ~clk;

    mats_bist #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .start(start),
        .func_addr(func_addr), .func_we(func_we), .func_wdata(func_wdata),
        .ag_addr(ag_addr), .ag_last(ag_last), .ram_rdata(ram_rdata),
        .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata),
        .amux_sel(amux_sel), .ag_en(ag_en), .ag_up(ag_up),
        .done(done), .pass(pass), .fail(fail)
    );

    // Up/down address stepper model: wraps at both ends.
    always @(posedge clk) begin
        if (rst)        ag_addr <= '0;
        else if (ag_en) ag_addr <= ag_up ? ag_addr + 1'b1 : ag_addr - 1'b1;
    end
    assign ag_last = ag_up ? (ag_addr == AW'(N - 1)) : (ag_addr == '0);

    // One-bit RAM with a stuck-cell option on reads.
    always @(posedge clk) begin
        if (rst) mem <= N'(16'hA5C3);
        else if (ram_we) mem[ram_addr] <= ram_wdata;
        ram_rdata <= (flt_on && ram_addr == flt_addr) ? flt_val : mem[ram_addr];
    end

    // Write order monitor for the test elements (R4, R5, R6).
    always @(posedge clk) begin
        if (rst) begin
            wr_idx <= 0;
            wr_bad <= 0;
        end else if (amux_sel && ram_we) begin
            int ea;
            logic ed;
            if (wr_idx < N)          begin ea = wr_idx;         ed = 1'b0; end
            else if (wr_idx < 2 * N) begin ea = wr_idx - N;     ed = 1'b1; end
            else                     begin ea = 3 * N - 1 - wr_idx; ed = 1'b0; end
            if (int'(ram_addr) != ea || ram_wdata != ed) wr_bad <= wr_bad + 1;
            wr_idx <= wr_idx + 1;
        end
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_test(output int edges);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        edges = 1;
        while (!done && edges < 1000) begin
            @(negedge clk);
            edges++;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(!amux_sel && !ag_en && !done && !pass && !fail, "R1 idle in reset",
              {amux_sel, ag_en, done, pass, fail}, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check(!amux_sel && !done, "R3 no start no test", {amux_sel, done}, 0);
    endtask

    task automatic t_passthru();
        @(negedge clk);
        func_addr = 4'd9; func_we = 1'b1; func_wdata = 1'b1;
        #1;
        check(ram_addr == 4'd9 && ram_we && ram_wdata, "R2 functional path",
              {ram_addr, ram_we, ram_wdata}, {4'd9, 2'b11});
        func_we = 1'b0; func_wdata = 1'b0; func_addr = '0;
        #1;
    endtask

    task automatic t_good();
        int n;
        do_reset();
        run_test(n);
        check(n == 5 * N + 2, "R8 pass latency", n, 5 * N + 2);
        check(pass && !fail && done, "R9 pass flags", {done, pass, fail}, 3'b110);
        check(wr_idx == 3 * N, "R5 write count", wr_idx, 3 * N);
        check(wr_bad == 0, "R4 R6 write order and data", wr_bad, 0);
        check(mem == '0, "R5 final contents zero", int'(mem), 0);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        check(pass && done && !amux_sel && !ag_en, "R3 start ignored after end",
              {pass, done, amux_sel, ag_en}, 4'b1100);
        func_addr = 4'd3; func_we = 1'b1; func_wdata = 1'b0;
        #1;
        check(ram_addr == 4'd3 && ram_we, "R2 path restored after pass",
              ram_addr, 3);
        func_we = 1'b0;
    endtask

    task automatic t_fault(input logic [AW-1:0] a, input logic v, input int exp_n, input string tag);
        int n;
        flt_on = 1'b1; flt_addr = a; flt_val = v;
        do_reset();
        run_test(n);
        check(n == exp_n, {tag, " fail latency"}, n, exp_n);
        check(fail && done && !pass && !amux_sel, {tag, " fail flags"},
              {fail, done, pass, amux_sel}, 4'b1100);
        repeat (8) @(negedge clk);
        check(fail && !pass && !ag_en, {tag, " fail held"}, {fail, pass, ag_en}, 3'b100);
        flt_on = 1'b0;
    endtask

    initial begin
        t_reset();
        t_passthru();
        t_good();
        t_fault(4'd0,  1'b1, 20, "R7 stuck-1 first address");
        t_fault(4'd15, 1'b1, 50, "R7 stuck-1 last ascending address");
        t_fault(4'd9,  1'b0, 64, "R7 stuck-0 descending");
        t_fault(4'd0,  1'b0, 5 * N + 2, "R7 stuck-0 last descending address");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule